// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block drives the external memory bus of an 8-bit controller core whose low address byte and data share one 8-bit port. It counts oscillator clocks into 12-clock machine cycles, numbered phase 0 to phase 11, and splits each cycle into two halves of six clocks. In a code-fetch cycle, each half strobes an address out with an address-latch pulse and then opens a program-read window. The instruction byte is captured at the end of that window.

The core can ask for an external data move. It gives a 16-bit address, a write flag, write data and an addressing kind. The kind is either a 16-bit pointer or an 8-bit register-indirect access, which takes its high byte from a port register value. The request is taken only at a machine-cycle boundary, and the whole next machine cycle becomes a data cycle. In a data cycle the second address-latch pulse and both program-read pulses are left out, and a six-clock read or write strobe is emitted instead. A protection input limits code fetches and pointer-based data moves to a 4K window by forcing the upper four high-address bits to zero.

Top module: `mbus_seq`

## Requirements
- R1: While rst_n is low, ale is 0, psen_n, rd_n and wr_n are 1, and ad_oe, dreq_ack and instr_valid are 0. The first machine cycle starts at phase 0 on the first clock edge after reset is released.
- R2: In a fetch cycle, ale is high in phases 0, 1, 6 and 7, and psen_n is low in phases 3–5 and 9–11. This gives two address-latch pulses and two program-read pulses per 12 clocks.
- R3: In a data cycle, ale is high only in phases 0 and 1, and psen_n stays high for all 12 phases. That is exactly one latch pulse and two read pulses fewer than a fetch cycle.
- R4: ad_oe is 1 and ad_out carries the low address byte in phases 0–2. In a fetch cycle this also holds in phases 6–8. The port is released (ad_oe 0) while psen_n is low.
- R5: ad_in is captured at the clock edges that end phases 5 and 11 of a fetch cycle. instr_valid is 1 for one clock with that byte on instr_data, during the next phase 6 or phase 0.
- R6: In a read cycle, rd_n is low in phases 4–9 and ad_oe is 0 from phase 3 to phase 11. ad_in is captured at the edge that ends phase 9, and rdata_valid is 1 with that byte on rdata during phase 10 only.
- R7: In a write cycle, wr_n is low in phases 4–9, and ad_out carries the write data with ad_oe 1 in phases 3–10.
- R8: hi_out carries the fetch address high byte in a fetch cycle. In a data cycle it carries daddr[15:8] when dwide=1, or the hi_sfr value captured at the cycle boundary when dwide=0.
- R9: When protect=1, hi_out[7:4] is 0 in fetch cycles and in cycles with dwide=1. Cycles with dwide=0 are not affected by protect.
- R10: dreq is sampled only at the clock edge that ends phase 11. If it is accepted, dreq_ack is 1 during phase 0 of the data cycle. A dreq raised and dropped between two boundaries leaves the next cycle a fetch.
- R11: The fetch address is sampled at the edge that ends phase 11 for the first half, and at the edge that ends phase 5 for the second half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | 16 | Code fetch address from the core |
| dreq | input | 1 | External data move request |
| dwide | input | 1 | 1: 16-bit pointer access, 0: 8-bit register-indirect |
| dwrite | input | 1 | 1: write, 0: read |
| daddr | input | 16 | Data move address (low byte only used when dwide=0) |
| dwdata | input | 8 | Write data |
| hi_sfr | input | 8 | High-port register value used for register-indirect moves |
| protect | input | 1 | Limit fetch and pointer accesses to 4K |
| ad_in | input | 8 | Multiplexed port input (instruction or read data) |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed port output value |
| ad_oe | output | 1 | Multiplexed port output enable |
| hi_out | output | 8 | High address port |
| instr_data | output | 8 | Captured instruction byte |
| instr_valid | output | 1 | instr_data valid pulse |
| rdata | output | 8 | Captured read data |
| rdata_valid | output | 1 | rdata valid pulse |
| dreq_ack | output | 1 | Data request accepted, high in phase 0 of the data cycle |

## Verification
Every phase of each machine cycle is compared against the expected strobe, port and high-byte values. The patterns are plain fetches with different addresses in each half, pointer reads and writes, register-indirect reads and writes, and each of these with protection on and off. The two address halves separate the sampling points of the two fetches. The protected register-indirect write shows that the clamp depends on the addressing kind and not on protection alone. A request pulse that ends before the boundary is followed by a fetch cycle, which shows that dreq is sampled only at the boundary. Pulse counts per cycle separate the skipped latch and program-read pulses from a shifted strobe window.

// File: rtl/mbus_seq_pkg.sv
package mbus_seq_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH  = 2'd0,
    CYC_DREAD  = 2'd1,
    CYC_DWRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr #(
  parameter int PER_MC = 12,
  parameter int PH_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase,
  output logic            run,
  output logic            mc_end,
  output logic            half_end
);
  localparam logic [PH_W-1:0] LAST      = PH_W'(PER_MC - 1);
  localparam logic [PH_W-1:0] HALF_LAST = PH_W'(PER_MC / 2 - 1);

  logic [PH_W-1:0] phase_q, phase_d;
  logic            run_q;

  always_comb begin
    phase_d = phase_q;
    if (run_q) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      run_q   <= 1'b1;
    end
  end

  assign phase    = phase_q;
  assign run      = run_q;
  assign mc_end   = run_q & (phase_q == LAST);
  assign half_end = run_q & (phase_q == HALF_LAST);

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mc_end |=> (phase_q == '0)); // R2
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST); // R2
endmodule

// File: rtl/mbus_cycle_ctl.sv
module mbus_cycle_ctl
  import mbus_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mc_end,
  input  logic              half_end,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              dreq,
  input  logic              dwide,
  input  logic              dwrite,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [DATA_W-1:0] dwdata,
  input  logic [DATA_W-1:0] hi_sfr,
  output cyc_kind_e         kind,
  output logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sfr,
  output logic              dack
);
  cyc_kind_e         kind_q, kind_d;
  logic              wide_q, wide_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] sfr_q, sfr_d;
  logic              dack_q, dack_d;
  logic              load_mc;

  // a new machine cycle is prepared at the boundary, or on the start edge
  assign load_mc = mc_end | ~run;

  always_comb begin
    kind_d  = kind_q;
    wide_d  = wide_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    sfr_d   = sfr_q;
    dack_d  = 1'b0;
    if (load_mc) begin
      if (dreq) begin
        kind_d = dwrite ? CYC_DWRITE : CYC_DREAD;
        addr_d = daddr;
        dack_d = 1'b1;
      end else begin
        kind_d = CYC_FETCH;
        addr_d = fetch_addr;
      end
      wide_d  = dwide;
      wdata_d = dwdata;
      sfr_d   = hi_sfr;
    end else if (half_end && kind_q == CYC_FETCH) begin
      addr_d = fetch_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_FETCH;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      sfr_q   <= '0;
      dack_q  <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      wide_q  <= wide_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      sfr_q   <= sfr_d;
      dack_q  <= dack_d;
    end
  end

  assign kind  = kind_q;
  assign wide  = wide_q;
  assign addr  = addr_q;
  assign wdata = wdata_q;
  assign sfr   = sfr_q;
  assign dack  = dack_q;

  AST_DACK_DATA_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dack_q |-> (kind_q != CYC_FETCH)); // R10
endmodule

// File: rtl/mbus_strobe_dec.sv
module mbus_strobe_dec
  import mbus_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int PER_MC    = 12,
  parameter int PH_W      = 4,
  parameter int KEEP_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [PH_W-1:0]          phase,
  input  cyc_kind_e                kind,
  input  logic                     wide,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        sfr,
  input  logic                     protect,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_out,
  output logic [DATA_W-1:0]        instr_data,
  output logic                     instr_valid,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_valid
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int HALF  = PER_MC / 2;
  localparam int ALE_W = 2;
  localparam int STB_S = ALE_W + 2;
  localparam int STB_E = STB_S + HALF - 1;
  localparam int WD_S  = ALE_W + 1;
  localparam int WD_E  = PER_MC - 2;

  int  p, hp;
  logic second, is_fetch, is_rd, is_wr, addr_ph;
  logic ale_c, psen_c, rd_c, wr_c, oe_c, clamp_en;
  logic [HI_W-1:0]   hi_raw;
  logic [DATA_W-1:0] instr_q, instr_d, rdata_q, rdata_d;
  logic              ival_q, ival_d, rval_q, rval_d;

  always_comb begin
    p        = int'(phase);
    second   = (p >= HALF);
    hp       = second ? p - HALF : p;
    is_fetch = (kind == CYC_FETCH);
    is_rd    = (kind == CYC_DREAD);
    is_wr    = (kind == CYC_DWRITE);
    addr_ph  = (hp <= ALE_W) && (!second || is_fetch);
    ale_c    = run && (hp < ALE_W) && (!second || is_fetch);
    psen_c   = run && is_fetch && (hp > ALE_W) && (hp <= HALF - 1);
    rd_c     = run && is_rd && (p >= STB_S) && (p <= STB_E);
    wr_c     = run && is_wr && (p >= STB_S) && (p <= STB_E);
    oe_c     = run && (addr_ph || (is_wr && (p >= WD_S) && (p <= WD_E)));
    hi_raw   = (!is_fetch && !wide) ? sfr : addr[ADDR_W-1:DATA_W];
    clamp_en = protect && (is_fetch || wide);
  end

  always_comb begin
    instr_d = instr_q;
    ival_d  = 1'b0;
    rdata_d = rdata_q;
    rval_d  = 1'b0;
    if (run && is_fetch && (p == HALF - 1 || p == PER_MC - 1)) begin
      instr_d = ad_in;
      ival_d  = 1'b1;
    end
    if (run && is_rd && p == STB_E) begin
      rdata_d = ad_in;
      rval_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      ival_q  <= 1'b0;
      rdata_q <= '0;
      rval_q  <= 1'b0;
    end else begin
      instr_q <= instr_d;
      ival_q  <= ival_d;
      rdata_q <= rdata_d;
      rval_q  <= rval_d;
    end
  end

  for (genvar gi = 0; gi < HI_W; gi++) begin : g_hi
    if (gi + DATA_W >= KEEP_BITS) begin : g_clamp
      assign hi_out[gi] = hi_raw[gi] & ~clamp_en;
    end else begin : g_pass
      assign hi_out[gi] = hi_raw[gi];
    end
  end

  assign ale         = ale_c;
  assign psen_n      = ~psen_c;
  assign rd_n        = ~rd_c;
  assign wr_n        = ~wr_c;
  assign ad_oe       = oe_c;
  assign ad_out      = addr_ph ? addr[DATA_W-1:0] : wdata;
  assign instr_data  = instr_q;
  assign instr_valid = ival_q;
  assign rdata       = rdata_q;
  assign rdata_valid = rval_q;

  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale); // R2
  AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n); // R3
  AST_ALE_DRIVES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe); // R4
  AST_PSEN_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ad_oe); // R4
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n); // R6
  AST_PROTECT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && (is_fetch || wide)) |-> ((hi_out >> (KEEP_BITS - DATA_W)) == '0)); // R9
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int PER_MC    = 12,
  parameter int KEEP_BITS = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     dreq,
  input  logic                     dwide,
  input  logic                     dwrite,
  input  logic [ADDR_W-1:0]        daddr,
  input  logic [DATA_W-1:0]        dwdata,
  input  logic [DATA_W-1:0]        hi_sfr,
  input  logic                     protect,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_out,
  output logic [DATA_W-1:0]        instr_data,
  output logic                     instr_valid,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_valid,
  output logic                     dreq_ack
);
  localparam int PH_W = $clog2(PER_MC);

  logic [PH_W-1:0]   phase;
  logic              run, mc_end, half_end, wide;
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, sfr;

  mbus_phase_ctr #(.PER_MC(PER_MC), .PH_W(PH_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .run(run),
    .mc_end(mc_end), .half_end(half_end)
  );

  mbus_cycle_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .run(run), .mc_end(mc_end), .half_end(half_end),
    .fetch_addr(fetch_addr), .dreq(dreq), .dwide(dwide), .dwrite(dwrite),
    .daddr(daddr), .dwdata(dwdata), .hi_sfr(hi_sfr),
    .kind(kind), .wide(wide), .addr(addr), .wdata(wdata), .sfr(sfr), .dack(dreq_ack)
  );

  mbus_strobe_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PER_MC(PER_MC),
                    .PH_W(PH_W), .KEEP_BITS(KEEP_BITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .kind(kind), .wide(wide),
    .addr(addr), .wdata(wdata), .sfr(sfr), .protect(protect), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .hi_out(hi_out), .instr_data(instr_data),
    .instr_valid(instr_valid), .rdata(rdata), .rdata_valid(rdata_valid)
  );

  AST_ACK_AT_PHASE0: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_ack |-> (phase == '0)); // R10
  AST_IDLE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!ale && psen_n && rd_n && wr_n && !ad_oe)); // R1
endmodule

// File: tb/tb_mbus_seq.sv
`timescale 1ns/1ps
module tb_mbus_seq;
  logic        clk, rst_n;
  logic [15:0] fetch_addr, daddr;
  logic        dreq, dwide, dwrite, protect;
  logic [7:0]  dwdata, hi_sfr, ad_in;
  logic        ale, psen_n, rd_n, wr_n, ad_oe, instr_valid, rdata_valid, dreq_ack;
  logic [7:0]  ad_out, hi_out, instr_data, rdata;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  bit   pend_instr = 0;
  logic [7:0] pend_val = 8'h00;

  mbus_seq dut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr), .dreq(dreq), .dwide(dwide),
    .dwrite(dwrite), .daddr(daddr), .dwdata(dwdata), .hi_sfr(hi_sfr),
    .protect(protect), .ad_in(ad_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .instr_data(instr_data), .instr_valid(instr_valid), .rdata(rdata),
    .rdata_valid(rdata_valid), .dreq_ack(dreq_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // kind: 0 fetch, 1 read, 2 write. Entered at the negedge of phase 11.
  task automatic run_cycle(input int kind, input bit wide, input bit prot,
                           input logic [15:0] a, input logic [15:0] b,
                           input logic [7:0] wd, input logic [7:0] sfr,
                           input logic [7:0] ia, input logic [7:0] ib,
                           input logic [7:0] rb, input bit glitch);
    bit isf;
    int ales, psens, hp;
    bit sec, adph, e_ale, e_psn, e_rdn, e_wrn, e_oe;
    logic pale, ppsn;
    logic [7:0] e_ad, e_hi;
    isf        = (kind == 0);
    fetch_addr = a;
    daddr      = a;
    dreq       = !isf;
    dwrite     = (kind == 2);
    dwide      = wide;
    dwdata     = wd;
    hi_sfr     = sfr;
    protect    = prot;
    pale = ale; ppsn = psen_n; ales = 0; psens = 0;
    for (int p = 0; p < 12; p++) begin
      @(negedge clk);
      if (p == 0) begin
        chk("R10", "dreq_ack", dreq_ack, !isf);
        chk("R5", "instr_valid at phase 0", instr_valid, pend_instr);
        if (pend_instr) chk("R5", "instr_data at phase 0", instr_data, pend_val);
        pend_instr = 0;
        dreq = 1'b0;
      end
      if (glitch && p == 3) dreq = 1'b1;
      if (glitch && p == 8) dreq = 1'b0;
      sec   = (p >= 6);
      hp    = sec ? p - 6 : p;
      adph  = (hp <= 2) && (!sec || isf);
      e_ale = (hp < 2) && (!sec || isf);
      e_psn = !(isf && hp >= 3 && hp <= 5);
      e_rdn = !(kind == 1 && p >= 4 && p <= 9);
      e_wrn = !(kind == 2 && p >= 4 && p <= 9);
      e_oe  = adph || (kind == 2 && p >= 3 && p <= 10);
      e_ad  = adph ? (sec ? b[7:0] : a[7:0]) : wd;
      if (isf)       e_hi = sec ? b[15:8] : a[15:8];
      else if (wide) e_hi = a[15:8];
      else           e_hi = sfr;
      if (prot && (isf || wide)) e_hi = e_hi & 8'h0F;
      chk(isf ? "R2" : "R3", $sformatf("ale phase %0d", p), ale, e_ale);
      chk(isf ? "R2" : "R3", $sformatf("psen_n phase %0d", p), psen_n, e_psn);
      chk("R6", $sformatf("rd_n phase %0d", p), rd_n, e_rdn);
      chk("R7", $sformatf("wr_n phase %0d", p), wr_n, e_wrn);
      chk("R4", $sformatf("ad_oe phase %0d", p), ad_oe, e_oe);
      if (e_oe) chk(adph ? (sec ? "R11" : "R4") : "R7",
                    $sformatf("ad_out phase %0d", p), ad_out, e_ad);
      chk(prot ? "R9" : "R8", $sformatf("hi_out phase %0d", p), hi_out, e_hi);
      if (ale && !pale) ales++;
      if (!psen_n && ppsn) psens++;
      pale = ale; ppsn = psen_n;
      if (p == 5) begin fetch_addr = b; ad_in = ia; end
      if (p == 6) begin
        chk("R5", "instr_valid at phase 6", instr_valid, isf);
        if (isf) chk("R5", "instr_data at phase 6", instr_data, ia);
      end
      if (p == 9) ad_in = rb;
      if (p == 10) begin
        chk("R6", "rdata_valid at phase 10", rdata_valid, kind == 1);
        if (kind == 1) chk("R6", "rdata", rdata, rb);
      end
      if (p == 11) begin
        ad_in = ib;
        pend_instr = isf;
        pend_val = ib;
      end
    end
    chk(isf ? "R2" : "R3", "ale pulses per cycle", 16'(ales), isf ? 16'd2 : 16'd1);
    chk(isf ? "R2" : "R3", "psen pulses per cycle", 16'(psens), isf ? 16'd2 : 16'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    fetch_addr = 16'h0000; daddr = 16'h0000; dreq = 1'b0; dwide = 1'b0;
    dwrite = 1'b0; dwdata = 8'h00; hi_sfr = 8'h00; protect = 1'b0; ad_in = 8'h00;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1", "ale in reset", ale, 1'b0);
      chk("R1", "psen_n in reset", psen_n, 1'b1);
      chk("R1", "rd_n/wr_n in reset", {rd_n, wr_n}, 2'b11);
      chk("R1", "ad_oe/ack/valid in reset", {ad_oe, dreq_ack, instr_valid}, 3'b000);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_fetch_plain();
    run_cycle(0, 0, 0, 16'h1234, 16'h5678, 8'h00, 8'h00, 8'hA1, 8'hB2, 8'h00, 0);
    run_cycle(0, 0, 0, 16'h9ABC, 16'hDEF0, 8'h00, 8'h00, 8'h3C, 8'hC3, 8'h00, 0);
  endtask

  task automatic t_fetch_protected();
    run_cycle(0, 0, 1, 16'hF3A5, 16'h8001, 8'h00, 8'h00, 8'h55, 8'hAA, 8'h00, 0);
  endtask

  task automatic t_read_wide();
    run_cycle(1, 1, 0, 16'hABCD, 16'h0000, 8'h00, 8'h11, 8'h00, 8'h00, 8'h6E, 0);
    run_cycle(1, 1, 1, 16'hBCDE, 16'h0000, 8'h00, 8'h11, 8'h00, 8'h00, 8'h91, 0);
  endtask

  task automatic t_write_narrow();
    run_cycle(2, 0, 1, 16'h0077, 16'h0000, 8'h4B, 8'hE4, 8'h00, 8'h00, 8'h00, 0);
    run_cycle(2, 0, 0, 16'h00C8, 16'h0000, 8'hD2, 8'h39, 8'h00, 8'h00, 8'h00, 0);
  endtask

  task automatic t_write_wide();
    run_cycle(2, 1, 0, 16'h7F10, 16'h0000, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 0);
  endtask

  task automatic t_read_narrow();
    run_cycle(1, 0, 1, 16'h0033, 16'h0000, 8'h00, 8'hF7, 8'h00, 8'h00, 8'h2D, 0);
  endtask

  task automatic t_dropped_request();
    run_cycle(0, 1, 0, 16'h2468, 16'h1357, 8'h00, 8'h00, 8'h77, 8'h88, 8'h00, 1);
    run_cycle(0, 0, 0, 16'h0246, 16'h8642, 8'h00, 8'h00, 8'h19, 8'h91, 8'h00, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fetch_plain();
    t_fetch_protected();
    t_read_wide();
    t_fetch_plain();
    t_write_narrow();
    t_write_wide();
    t_read_narrow();
    t_dropped_request();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule